// File: doc/BRIEF.md
# USB Frame Interval Timer

This block is the frame timing engine of a full-speed USB host controller. A down-counter runs through the bit times of each frame. When it has counted out a frame it reloads from a programmable interval, advances a 16-bit frame number and raises a start-of-frame pulse. A comparator flags the part of the frame in which periodic traffic has priority. That part begins once the remaining count has fallen to a programmable threshold.

Software sees the block as a small set of register views. The interval view is writable and holds the frame length, a full-speed maximum packet size and a toggle bit. Software flips the toggle bit whenever it changes the interval. The remaining view is read-only and shows the live count together with the toggle value captured at the last reload. The frame number is read-only. A periodic-start threshold and a low-speed threshold are both writable. Counting advances only on cycles where the controller is operational and the bit-time tick is high.

Top module: `usb_frame_timer`

## Requirements
- R1: After reset the remaining view reads 0x00000000 and the frame number reads 0. The start-of-frame and overflow pulses are low. The interval view reads 0x00002EDF (interval 11999, packet size 0, toggle 0). The periodic-start view reads 0x3E67 and the low-speed threshold reads 0x0628.
- R2: A write to the interval view stores the interval in bits 13:0, the packet size in bits 30:16 and the toggle in bit 31. Bits 15:14 always read 0. The periodic-start (14-bit) and low-speed (15-bit) thresholds read back exactly as written.
- R3: On each qualified tick (run_en and bit_tick both high) with a nonzero remaining count, the count drops by one and its bit 31 keeps its value.
- R4: On a qualified tick with a remaining count of 0, the count reloads from the interval field. Bit 31 of the remaining view takes the interval toggle bit, and bits 30:14 read 0.
- R5: The frame number increments modulo 65536 on every reload. sof_pulse is high for exactly the cycle in which the reloaded count first appears, and is low in every other cycle.
- R6: fno_pulse is high for one cycle whenever bit 15 of the frame number changes (0x7FFF to 0x8000, and 0xFFFF to 0x0000). It is low otherwise.
- R7: When run_en or bit_tick is low, the remaining view and the frame number hold their values and no pulse is raised. Register writes alone do not move the count.
- R8: periodic_pri is high exactly while the remaining count (bits 13:0) is less than or equal to the periodic-start threshold.
- R9: An interval write in the same cycle as a reload does not affect that reload. The reload uses the value held before the write, and the new value applies from the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Controller operational; counting allowed |
| bit_tick | input | 1 | One bit time elapsed |
| ivl_wr | input | 1 | Write strobe for the interval view |
| ivl_wdata | input | 32 | Interval view write data |
| pstart_wr | input | 1 | Write strobe for the periodic-start threshold |
| pstart_wdata | input | 14 | Periodic-start write data |
| lsthr_wr | input | 1 | Write strobe for the low-speed threshold |
| lsthr_wdata | input | 15 | Low-speed threshold write data |
| ivl_rd | output | 32 | Interval view |
| remain_rd | output | 32 | Remaining view: count in 13:0, toggle in 31 |
| frame_num | output | 16 | Current frame number |
| pstart_rd | output | 14 | Periodic-start threshold |
| lsthr_rd | output | 15 | Low-speed threshold |
| periodic_pri | output | 1 | Periodic traffic has priority |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame number bit 15 changed |

## Verification
The bench steps the counter through a short frame and watches the reload cycle. A design that reloaded one tick early or late, or that dropped or kept the toggle incorrectly, would show the wrong remaining value next to the start-of-frame pulse. With a zero-length interval, every tick becomes a frame, so the frame number can be driven across both bit-15 transitions. A design that flagged only the full wrap, or that pulsed on other carries, would miss the 0x8000 pulse or pulse spuriously. Further cases cover an interval write that lands on the reload cycle (a design that forwarded the new value would load it one frame early), idle cycles with only one of the two qualifiers high, and the threshold comparison at equality.

// File: rtl/ufrm_pkg.sv
package ufrm_pkg;
  localparam int REG_W      = 32;
  localparam int FI_W_DEF   = 14;
  localparam int MPS_W_DEF  = 15;
  localparam int LST_W_DEF  = 15;
  localparam int FN_W_DEF   = 16;
  localparam int MPS_LSB    = 16;
  localparam int TOG_BIT    = 31;
  localparam int FI_RST_DEF = 11999;
  localparam int PS_RST_DEF = 'h3E67;
  localparam int LS_RST_DEF = 'h0628;
endpackage

// File: rtl/ufrm_regs.sv
module ufrm_regs
  import ufrm_pkg::*;
#(
  parameter int FI_W   = FI_W_DEF,
  parameter int MPS_W  = MPS_W_DEF,
  parameter int LST_W  = LST_W_DEF,
  parameter int FI_RST = FI_RST_DEF,
  parameter int PS_RST = PS_RST_DEF,
  parameter int LS_RST = LS_RST_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ivl_wr,
  input  logic [REG_W-1:0] ivl_wdata,
  input  logic             pstart_wr,
  input  logic [FI_W-1:0]  pstart_wdata,
  input  logic             lsthr_wr,
  input  logic [LST_W-1:0] lsthr_wdata,
  output logic [FI_W-1:0]  fi,
  output logic [MPS_W-1:0] mps,
  output logic             tog,
  output logic [FI_W-1:0]  pstart,
  output logic [LST_W-1:0] lsthr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fi     <= FI_W'(FI_RST);
      mps    <= '0;
      tog    <= 1'b0;
      pstart <= FI_W'(PS_RST);
      lsthr  <= LST_W'(LS_RST);
    end else begin
      if (ivl_wr) begin
        fi  <= ivl_wdata[FI_W-1:0];
        mps <= ivl_wdata[MPS_LSB +: MPS_W];
        tog <= ivl_wdata[TOG_BIT];
      end
      if (pstart_wr) pstart <= pstart_wdata;
      if (lsthr_wr)  lsthr  <= lsthr_wdata;
    end
  end

  AST_IVL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_wr |=> (fi == $past(ivl_wdata[FI_W-1:0]) && tog == $past(ivl_wdata[TOG_BIT]))); // R2
endmodule

// File: rtl/ufrm_down_counter.sv
module ufrm_down_counter #(
  parameter int FI_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  input  logic [FI_W-1:0] fi,
  input  logic            tog_in,
  output logic [FI_W-1:0] rem,
  output logic            rem_tog,
  output logic            reload_evt,
  output logic            sof
);
  function automatic logic [FI_W-1:0] next_count(input logic [FI_W-1:0] cur,
                                                 input logic [FI_W-1:0] ival);
    return (cur == '0) ? ival : cur - FI_W'(1);
  endfunction

  assign reload_evt = adv && (rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem     <= '0;
      rem_tog <= 1'b0;
      sof     <= 1'b0;
    end else begin
      sof <= reload_evt;
      if (adv) rem <= next_count(rem, fi);
      if (reload_evt) rem_tog <= tog_in;
    end
  end

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rem != '0) |=> (rem == $past(rem) - FI_W'(1) && $stable(rem_tog) && !sof)); // R3
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && rem == '0) |=> (rem == $past(fi) && rem_tog == $past(tog_in) && sof)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(rem) && $stable(rem_tog) && !sof)); // R7
endmodule

// File: rtl/ufrm_frame_num.sv
module ufrm_frame_num #(
  parameter int FN_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  output logic [FN_W-1:0] frame,
  output logic            ovf
);
  function automatic logic top_flips(input logic [FN_W-1:0] a,
                                     input logic [FN_W-1:0] b);
    return a[FN_W-1] ^ b[FN_W-1];
  endfunction

  logic [FN_W-1:0] frame_nxt;
  assign frame_nxt = frame + FN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= step && top_flips(frame, frame_nxt);
      if (step) frame <= frame_nxt;
    end
  end

  AST_FRAME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (frame == FN_W'($past(frame) + FN_W'(1)))); // R5
  AST_OVF_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (frame[FN_W-1] != $past(frame[FN_W-1]))); // R6
  AST_OVF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (!ovf && $stable(frame))); // R6
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer
  import ufrm_pkg::*;
#(
  parameter int FI_W   = FI_W_DEF,
  parameter int MPS_W  = MPS_W_DEF,
  parameter int LST_W  = LST_W_DEF,
  parameter int FN_W   = FN_W_DEF,
  parameter int FI_RST = FI_RST_DEF,
  parameter int PS_RST = PS_RST_DEF,
  parameter int LS_RST = LS_RST_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             bit_tick,
  input  logic             ivl_wr,
  input  logic [31:0]      ivl_wdata,
  input  logic             pstart_wr,
  input  logic [FI_W-1:0]  pstart_wdata,
  input  logic             lsthr_wr,
  input  logic [LST_W-1:0] lsthr_wdata,
  output logic [31:0]      ivl_rd,
  output logic [31:0]      remain_rd,
  output logic [FN_W-1:0]  frame_num,
  output logic [FI_W-1:0]  pstart_rd,
  output logic [LST_W-1:0] lsthr_rd,
  output logic             periodic_pri,
  output logic             sof_pulse,
  output logic             fno_pulse
);
  function automatic logic in_periodic(input logic [FI_W-1:0] left,
                                       input logic [FI_W-1:0] thr);
    return left <= thr;
  endfunction

  logic [FI_W-1:0]  fi, rem;
  logic [MPS_W-1:0] mps;
  logic             tog, rem_tog;
  logic             adv;
  logic             reload_evt;

  assign adv = run_en && bit_tick;

  ufrm_regs #(
    .FI_W(FI_W), .MPS_W(MPS_W), .LST_W(LST_W),
    .FI_RST(FI_RST), .PS_RST(PS_RST), .LS_RST(LS_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
    .pstart_wr(pstart_wr), .pstart_wdata(pstart_wdata),
    .lsthr_wr(lsthr_wr), .lsthr_wdata(lsthr_wdata),
    .fi(fi), .mps(mps), .tog(tog),
    .pstart(pstart_rd), .lsthr(lsthr_rd)
  );

  ufrm_down_counter #(.FI_W(FI_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .fi(fi), .tog_in(tog),
    .rem(rem), .rem_tog(rem_tog),
    .reload_evt(reload_evt), .sof(sof_pulse)
  );

  ufrm_frame_num #(.FN_W(FN_W)) u_fn (
    .clk(clk), .rst_n(rst_n), .step(reload_evt),
    .frame(frame_num), .ovf(fno_pulse)
  );

  always_comb begin
    ivl_rd                    = '0;
    ivl_rd[FI_W-1:0]          = fi;
    ivl_rd[MPS_LSB +: MPS_W]  = mps;
    ivl_rd[TOG_BIT]           = tog;
    remain_rd                 = '0;
    remain_rd[FI_W-1:0]       = rem;
    remain_rd[TOG_BIT]        = rem_tog;
  end

  assign periodic_pri = in_periodic(rem, pstart_rd);

  AST_SOF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (frame_num != $past(frame_num))); // R5
  AST_SOF_ONLY_ON_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_evt |=> !sof_pulse); // R5
endmodule

// File: tb/usb_frame_timer_tb.sv
module usb_frame_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_en = 1'b0, bit_tick = 1'b0;
  logic        ivl_wr = 1'b0, pstart_wr = 1'b0, lsthr_wr = 1'b0;
  logic [31:0] ivl_wdata = '0;
  logic [13:0] pstart_wdata = '0;
  logic [14:0] lsthr_wdata = '0;
  logic [31:0] ivl_rd, remain_rd;
  logic [15:0] frame_num;
  logic [13:0] pstart_rd;
  logic [14:0] lsthr_rd;
  logic        periodic_pri, sof_pulse, fno_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  usb_frame_timer u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .bit_tick(bit_tick),
    .ivl_wr(ivl_wr), .ivl_wdata(ivl_wdata),
    .pstart_wr(pstart_wr), .pstart_wdata(pstart_wdata),
    .lsthr_wr(lsthr_wr), .lsthr_wdata(lsthr_wdata),
    .ivl_rd(ivl_rd), .remain_rd(remain_rd), .frame_num(frame_num),
    .pstart_rd(pstart_rd), .lsthr_rd(lsthr_rd),
    .periodic_pri(periodic_pri), .sof_pulse(sof_pulse), .fno_pulse(fno_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic run, input logic tk, input logic iw, input logic [31:0] iv);
    @(negedge clk);
    run_en = run; bit_tick = tk; ivl_wr = iw; ivl_wdata = iv;
    @(posedge clk); #1;
    ivl_wr = 1'b0; bit_tick = 1'b0;
  endtask

  task automatic wr_thr(input logic pw, input logic [13:0] pv, input logic lw, input logic [14:0] lv);
    @(negedge clk);
    pstart_wr = pw; pstart_wdata = pv; lsthr_wr = lw; lsthr_wdata = lv;
    @(posedge clk); #1;
    pstart_wr = 1'b0; lsthr_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 remain", remain_rd, 32'h0);
    chk("R1 frame", {16'h0, frame_num}, 32'h0);
    chk("R1 pulses", {30'h0, sof_pulse, fno_pulse}, 32'h0);
    chk("R1 interval", ivl_rd, 32'h0000_2EDF);
    chk("R1 pstart", {18'h0, pstart_rd}, 32'h3E67);
    chk("R1 lsthr", {17'h0, lsthr_rd}, 32'h0628);
  endtask

  task automatic t_regs;
    step(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF);
    chk("R2 interval mask", ivl_rd, 32'hFFFF_3FFF);
    wr_thr(1'b1, 14'h2AB5, 1'b1, 15'h7FFF);
    chk("R2 pstart", {18'h0, pstart_rd}, 32'h2AB5);
    chk("R2 lsthr", {17'h0, lsthr_rd}, 32'h7FFF);
    chk("R7 writes do not count", remain_rd, 32'h0);
    chk("R7 no sof on writes", {31'h0, sof_pulse}, 32'h0);
    wr_thr(1'b1, 14'h3E67, 1'b0, 15'h0);
  endtask

  task automatic t_reload;
    step(1'b1, 1'b0, 1'b1, 32'h8000_0005);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R4 reload with toggle", remain_rd, 32'h8000_0005);
    chk("R5 sof on reload", {31'h0, sof_pulse}, 32'h1);
    chk("R5 frame 1", {16'h0, frame_num}, 32'h1);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R3 decrement", remain_rd, 32'h8000_0004);
    chk("R5 sof one cycle", {31'h0, sof_pulse}, 32'h0);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R3 down to zero", remain_rd, 32'h8000_0000);
    chk("R5 frame held while counting", {16'h0, frame_num}, 32'h1);
    step(1'b1, 1'b0, 1'b1, 32'h0000_0002);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R4 toggle cleared on reload", remain_rd, 32'h0000_0002);
    chk("R5 frame 2", {16'h0, frame_num}, 32'h2);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, 32'h0);
    chk("R7 run low holds count", remain_rd, 32'h0000_0002);
    chk("R7 run low no sof", {31'h0, sof_pulse}, 32'h0);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 32'h0);
    chk("R7 tick low holds count", remain_rd, 32'h0000_0002);
    chk("R7 frame held", {16'h0, frame_num}, 32'h2);
  endtask

  task automatic t_pri;
    wr_thr(1'b1, 14'h0001, 1'b0, 15'h0);
    chk("R8 above threshold", {31'h0, periodic_pri}, 32'h0);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R8 equal threshold", {31'h0, periodic_pri}, 32'h1);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R8 below threshold", {31'h0, periodic_pri}, 32'h1);
    chk("R3 reached zero", remain_rd, 32'h0);
    wr_thr(1'b1, 14'h3E67, 1'b0, 15'h0);
  endtask

  task automatic t_race;
    step(1'b1, 1'b1, 1'b1, 32'h8000_0007);
    chk("R9 reload uses old interval", remain_rd, 32'h0000_0002);
    chk("R9 frame 3", {16'h0, frame_num}, 32'h3);
    chk("R9 new value stored", ivl_rd, 32'h8000_0007);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R9 next reload uses new interval", remain_rd, 32'h8000_0007);
    chk("R9 frame 4", {16'h0, frame_num}, 32'h4);
  endtask

  task automatic t_fno;
    int spurious = 0;
    int guard = 0;
    step(1'b1, 1'b0, 1'b1, 32'h0);
    while (!sof_pulse && guard < 20) begin
      step(1'b1, 1'b1, 1'b0, 32'h0);
      guard++;
    end
    while (frame_num != 16'h7FFF && guard < 70000) begin
      step(1'b1, 1'b1, 1'b0, 32'h0);
      if (fno_pulse) spurious++;
      guard++;
    end
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R6 frame 0x8000", {16'h0, frame_num}, 32'h8000);
    chk("R6 pulse at 0x8000", {31'h0, fno_pulse}, 32'h1);
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R6 pulse one cycle", {31'h0, fno_pulse}, 32'h0);
    while (frame_num != 16'hFFFF && guard < 140000) begin
      step(1'b1, 1'b1, 1'b0, 32'h0);
      if (fno_pulse) spurious++;
      guard++;
    end
    step(1'b1, 1'b1, 1'b0, 32'h0);
    chk("R5 frame wraps to 0", {16'h0, frame_num}, 32'h0);
    chk("R6 pulse at wrap", {31'h0, fno_pulse}, 32'h1);
    chk("R6 no pulse elsewhere", spurious, 32'h0);
    chk("R5 sof every tick with zero interval", {31'h0, sof_pulse}, 32'h1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    t_reset();
    t_regs();
    t_reload();
    t_hold();
    t_pri();
    t_race();
    t_fno();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule